// File: doc/BRIEF.md
# Quadword-Slotted Register Window with Push FIFO

This block is the memory-mapped slave front end of a packet-unpacking engine. It decodes byte-granular bus accesses into two address regions. The register region holds twenty-four registers, each given its own 16-byte quadword slot. The push region is one quadword wide and accepts only whole 128-bit writes. Each accepted push is appended to a small in-order FIFO, which a downstream consumer drains through a valid/ready pop port.

A request is sampled on a clock edge. A response with an ok flag and the read data is returned on the next edge. A request is refused, and no state changes, in any of these cases: its first and last byte lie in different quadwords, its byte count is zero or above sixteen, it hits no mapped region, or it targets a register slot that the instance does not implement. The parameter `FULL_INST` selects the instance. The reduced instance (0) locks five slots. The full instance (1) opens all twenty-four.

Byte lanes are address-aligned. The byte at address `a` travels on bits `[8*(a mod 16) +: 8]` of the 128-bit write and read data buses.

Top module: `qslot_regwin`

## Requirements
- R1: After reset every register slot reads as zero, the FIFO is empty (`pop_valid` low, `fifo_level` zero) and `rsp_valid` is low.
- R2: An accepted register write updates only the byte lanes from `addr mod 16` to `addr mod 16 + size - 1` of the slot. An accepted read returns those lanes of the slot and zero in every other lane.
- R3: The register slot index is `(addr - REG_BASE) >> 4`. The indices 0x00 to 0x17 are valid, and distinct slots hold independent values.
- R4: An access whose first and last byte fall in different quadwords gets `rsp_ok` = 0 and changes no state.
- R5: When `FULL_INST` = 0, reads and writes to slots 0x0a, 0x0b, 0x0c, 0x0e and 0x0f are refused and leave those slots unchanged, while every other slot, including 0x0d, is accessible. When `FULL_INST` = 1, all 24 slots are accessible.
- R6: A write to the push region is accepted only when its size is exactly 16 bytes. Any other size is refused and nothing is pushed.
- R7: A read of the push region is refused, and its `rsp_rdata` is zero.
- R8: Accepted pushes leave through the pop port in arrival order, one entry for each cycle in which `pop_valid` and `pop_ready` are both high.
- R9: A push while the FIFO holds `FIFO_DEPTH` entries is refused, and the stored entries stay intact.
- R10: An access with a size of zero, or one that hits neither region (for example register slot 0x18), is refused.
- R11: Every request produces exactly one response, with `rsp_valid` high in the cycle after the request and low when no request came the cycle before. Refused accesses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write data on address-aligned byte lanes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | 1 = access accepted |
| rsp_rdata | output | 128 | Read data on address-aligned lanes, zero when refused |
| pop_valid | output | 1 | FIFO head entry available |
| pop_ready | input | 1 | Consumer takes the head entry |
| pop_data | output | 128 | FIFO head entry |
| fifo_level | output | LVL_W | Number of stored FIFO entries |

## Verification
Register accesses are tried as whole-quadword words, as narrow fields at odd lane offsets, and as sub-word reads of a wider written value. Together these show whether lane placement and masking are right, as opposed to the slot as a whole simply being stored. Accesses that straddle a slot edge, have zero size, fall past the last slot, or hit locked slots are issued on a reduced and a full instance side by side. This separates the instance-dependent lock from the general refusal paths, and each refusal is followed by a read-back to show that nothing changed. The push region is driven with short writes, reads, a run up to full, an extra push when full, and a drain, so that the size check, the overflow refusal and the ordering can each be seen on their own.

// File: rtl/qslot_pkg.sv
package qslot_pkg;
  localparam int QW_BYTES = 16;
  localparam int QW_BITS  = QW_BYTES * 8;
  localparam int SIZE_W   = $clog2(QW_BYTES + 1);
  localparam int NSLOT    = 24;
  localparam int IDX_W    = $clog2(NSLOT);

  // Byte lanes touched by an access starting at lane off, cnt bytes long.
  function automatic logic [QW_BYTES-1:0] lane_mask(input logic [3:0] off,
                                                    input logic [SIZE_W-1:0] cnt);
    logic [QW_BYTES-1:0] m;
    for (int k = 0; k < QW_BYTES; k++)
      m[k] = (k >= int'(off)) && (k < int'(off) + int'(cnt));
    return m;
  endfunction

  // Slots that the reduced instance does not implement.
  function automatic logic slot_locked(input logic [IDX_W-1:0] idx);
    return (idx == 5'h0a) || (idx == 5'h0b) || (idx == 5'h0c) ||
           (idx == 5'h0e) || (idx == 5'h0f);
  endfunction

  // Expand a byte mask to a bit mask.
  function automatic logic [QW_BITS-1:0] bit_mask(input logic [QW_BYTES-1:0] m);
    logic [QW_BITS-1:0] b;
    for (int k = 0; k < QW_BYTES; k++) b[8*k +: 8] = {8{m[k]}};
    return b;
  endfunction
endpackage

// File: rtl/qslot_decode.sv
module qslot_decode
  import qslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0800,
  parameter logic [ADDR_W-1:0] FIFO_BASE = 16'h8000,
  parameter bit FULL_INST = 1'b0
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              fifo_full,
  output logic              acc_ok,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              fifo_push,
  output logic              crosses,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [QW_BYTES-1:0] lanes
);
  localparam logic [ADDR_W:0] REG_END  = {1'b0, REG_BASE} + (ADDR_W+1)'(NSLOT * QW_BYTES);
  localparam logic [ADDR_W:0] FIFO_END = {1'b0, FIFO_BASE} + (ADDR_W+1)'(QW_BYTES);

  logic [ADDR_W:0]   last_byte;
  logic [ADDR_W-1:0] off;
  logic bad_size, in_reg, in_fifo, reg_open;

  always_comb begin
    last_byte = {1'b0, addr} + (ADDR_W+1)'(size) - (ADDR_W+1)'(1);
    crosses   = last_byte[ADDR_W:4] != {1'b0, addr[ADDR_W-1:4]};
    bad_size  = (size == '0) || (int'(size) > QW_BYTES);
    in_reg    = ({1'b0, addr} >= {1'b0, REG_BASE}) && ({1'b0, addr} < REG_END);
    in_fifo   = ({1'b0, addr} >= {1'b0, FIFO_BASE}) && ({1'b0, addr} < FIFO_END);
    off       = addr - REG_BASE;
    slot_idx  = off[IDX_W+3:4];
    lanes     = lane_mask(addr[3:0], size);
    reg_open  = in_reg && (FULL_INST || !slot_locked(slot_idx));
    acc_ok    = valid && !bad_size && !crosses &&
                (reg_open || (in_fifo && write && int'(size) == QW_BYTES && !fifo_full));
    reg_wr    = acc_ok && in_reg && write;
    reg_rd    = acc_ok && in_reg && !write;
    fifo_push = acc_ok && in_fifo;
  end
endmodule

// File: rtl/qslot_regbank.sv
module qslot_regbank
  import qslot_pkg::*;
#(
  parameter bit FULL_INST = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [QW_BYTES-1:0] lanes,
  input  logic [QW_BITS-1:0]  wdata,
  output logic [QW_BITS-1:0]  rdata
);
  logic [QW_BITS-1:0] slot_q [NSLOT];
  logic [QW_BITS-1:0] wmask;

  assign wmask = bit_mask(lanes);
  assign rdata = (int'(idx) < NSLOT) ? (slot_q[idx] & wmask) : '0;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[s] <= '0;
      else if (wr_en && int'(idx) == s)
        slot_q[s] <= (slot_q[s] & ~wmask) | (wdata & wmask);
    end
  end

  // R5: a write strobe never reaches a slot the instance lacks
  assert_locked_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (FULL_INST || !slot_locked(idx)));
  // R3: write strobe only inside the slot range
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(idx) < NSLOT);
endmodule

// File: rtl/qslot_fifo.sv
module qslot_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = int'(level) == DEPTH;
  assign pop_valid = level != '0;
  assign pop       = pop_valid && pop_ready;
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end

  // R9: the decoder never pushes into a full FIFO
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  // R8: occupancy follows the handshakes
  assert_level_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_valid) |=> level == LVL_W'(1));
endmodule

// File: rtl/qslot_regwin.sv
module qslot_regwin
  import qslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0800,
  parameter logic [ADDR_W-1:0] FIFO_BASE = 16'h8000,
  parameter bit FULL_INST = 1'b0,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [4:0]         req_size,
  input  logic [127:0]       req_wdata,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [127:0]       rsp_rdata,
  output logic               pop_valid,
  input  logic               pop_ready,
  output logic [127:0]       pop_data,
  output logic [LVL_W-1:0]   fifo_level
);
  logic acc_ok, reg_wr, reg_rd, fifo_push, crosses, fifo_full;
  logic [IDX_W-1:0] slot_idx;
  logic [QW_BYTES-1:0] lanes;
  logic [QW_BITS-1:0] bank_rdata;

  qslot_decode #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .FIFO_BASE(FIFO_BASE),
                 .FULL_INST(FULL_INST)) u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
    .fifo_full(fifo_full), .acc_ok(acc_ok), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .fifo_push(fifo_push), .crosses(crosses), .slot_idx(slot_idx), .lanes(lanes));

  qslot_regbank #(.FULL_INST(FULL_INST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(slot_idx), .lanes(lanes),
    .wdata(req_wdata), .rdata(bank_rdata));

  qslot_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(QW_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(req_wdata),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .full(fifo_full), .level(fifo_level));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= acc_ok;
      rsp_rdata <= reg_rd ? bank_rdata : '0;
    end
  end

  // R11: one response per request, in the next cycle
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4: a straddling access is refused
  assert_cross_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && crosses) |=> !rsp_ok);
  // R7: refused accesses carry no data
  assert_refused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> rsp_rdata == '0);
  // R6: a push is always a full-quadword write
  assert_push_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (req_write && req_size == 5'd16));
endmodule

// File: tb/qslot_regwin_test.sv
`timescale 1ns/1ps
module qslot_regwin_test;
  localparam logic [15:0] RB = 16'h0800;
  localparam logic [15:0] FB = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pop_ready = 1'b0;
  logic [15:0] req_addr = '0;
  logic [4:0] req_size = '0;
  logic [127:0] req_wdata = '0;
  logic rv0, ok0, pv0, rv1, ok1, pv1;
  logic [127:0] rd0, pd0, rd1, pd1;
  logic [2:0] lvl0, lvl1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qslot_regwin #(.FULL_INST(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rv0), .rsp_ok(ok0), .rsp_rdata(rd0), .pop_valid(pv0),
    .pop_ready(pop_ready), .pop_data(pd0), .fifo_level(lvl0));

  qslot_regwin #(.FULL_INST(1'b1)) uut_full (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rv1), .rsp_ok(ok1), .rsp_rdata(rd1), .pop_valid(pv1),
    .pop_ready(pop_ready), .pop_data(pd1), .fifo_level(lvl1));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access; results sampled at the negedge after the capturing edge.
  task automatic acc(input logic w, input logic [15:0] a, input logic [4:0] n,
                     input logic [127:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = n; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid", {127'd0, rv0}, 128'd1);
  endtask

  function automatic logic [15:0] slot(input int i, input int byte_off);
    return RB + 16'(i * 16 + byte_off);
  endfunction

  task automatic t_reset();
    acc(1'b0, slot(0, 0), 5'd16, '0);
    chk("R1 slot0 ok", {127'd0, ok0}, 128'd1);
    chk("R1 slot0 zero", rd0, '0);
    acc(1'b0, slot(23, 0), 5'd16, '0);
    chk("R1 slot23 zero", rd0, '0);
    chk("R1 fifo level", {125'd0, lvl0}, '0);
    chk("R1 pop_valid", {127'd0, pv0}, '0);
    @(negedge clk);
    chk("R11 idle rsp_valid", {127'd0, rv0}, '0);
  endtask

  task automatic t_word_rw();
    acc(1'b1, slot(5, 0), 5'd4, 128'hA5A5_1234);
    chk("R2 word write ok", {127'd0, ok0}, 128'd1);
    acc(1'b1, slot(7, 0), 5'd4, 128'h0BAD_F00D);
    acc(1'b0, slot(5, 0), 5'd16, '0);
    chk("R3 slot5 readback", rd0, 128'hA5A5_1234);
    acc(1'b0, slot(7, 0), 5'd16, '0);
    chk("R3 slot7 independent", rd0, 128'h0BAD_F00D);
  endtask

  task automatic t_lanes();
    acc(1'b1, slot(16, 6), 5'd2, 128'hBEEF << 48);
    acc(1'b0, slot(16, 0), 5'd16, '0);
    chk("R2 lanes 6-7 only", rd0, 128'hBEEF << 48);
    acc(1'b0, slot(16, 7), 5'd1, '0);
    chk("R2 single byte read", rd0, 128'hBE << 56);
    acc(1'b1, slot(5, 1), 5'd1, 128'h77 << 8);
    acc(1'b0, slot(5, 0), 5'd16, '0);
    chk("R2 merge one lane", rd0, 128'hA5A5_7734);
    acc(1'b1, slot(23, 12), 5'd4, 128'hCAFE_0001 << 96);
    acc(1'b0, slot(23, 12), 5'd4, '0);
    chk("R3 last slot", rd0, 128'hCAFE_0001 << 96);
  endtask

  task automatic t_cross();
    acc(1'b1, slot(5, 14), 5'd4, '1);
    chk("R4 cross write refused", {127'd0, ok0}, '0);
    acc(1'b0, slot(5, 0), 5'd16, '0);
    chk("R4 slot5 unchanged", rd0, 128'hA5A5_7734);
    acc(1'b0, slot(6, 15), 5'd2, '0);
    chk("R4 cross read refused", {127'd0, ok0}, '0);
  endtask

  task automatic t_locked();
    acc(1'b1, slot(10, 0), 5'd4, 128'h1111_2222);
    chk("R5 reduced write 0x0a refused", {127'd0, ok0}, '0);
    chk("R5 full write 0x0a ok", {127'd0, ok1}, 128'd1);
    acc(1'b0, slot(10, 0), 5'd16, '0);
    chk("R5 reduced read 0x0a refused", {127'd0, ok0}, '0);
    chk("R5 reduced read data zero", rd0, '0);
    chk("R5 full readback 0x0a", rd1, 128'h1111_2222);
    acc(1'b1, slot(15, 0), 5'd4, 128'h5);
    chk("R5 reduced write 0x0f refused", {127'd0, ok0}, '0);
    acc(1'b1, slot(13, 0), 5'd4, 128'h3333);
    chk("R5 reduced 0x0d open", {127'd0, ok0}, 128'd1);
  endtask

  task automatic t_unmapped();
    acc(1'b0, slot(24, 0), 5'd4, '0);
    chk("R10 slot 0x18 refused", {127'd0, ok0}, '0);
    acc(1'b1, slot(1, 0), 5'd0, '1);
    chk("R10 zero size refused", {127'd0, ok0}, '0);
    acc(1'b0, slot(1, 0), 5'd16, '0);
    chk("R10 slot1 unchanged", rd0, '0);
  endtask

  task automatic t_fifo_rules();
    acc(1'b1, FB, 5'd8, 128'h99);
    chk("R6 short push refused", {127'd0, ok0}, '0);
    chk("R6 nothing pushed", {125'd0, lvl0}, '0);
    acc(1'b0, FB, 5'd16, '0);
    chk("R7 fifo read refused", {127'd0, ok0}, '0);
    chk("R7 fifo read data zero", rd0, '0);
  endtask

  task automatic t_fifo_order();
    for (int i = 0; i < 4; i++) begin
      acc(1'b1, FB, 5'd16, {32'(i + 1), 64'h0, 32'hF0F0_0000 + 32'(i)});
      chk("R8 push accepted", {127'd0, ok0}, 128'd1);
    end
    chk("R9 level at depth", {125'd0, lvl0}, 128'd4);
    acc(1'b1, FB, 5'd16, '1);
    chk("R9 push when full refused", {127'd0, ok0}, '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 pop order", pd0, {32'(i + 1), 64'h0, 32'hF0F0_0000 + 32'(i)});
      pop_ready = 1'b1;
      @(negedge clk);
      pop_ready = 1'b0;
    end
    chk("R8 drained", {127'd0, pv0}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word_rw();
    t_lanes();
    t_cross();
    t_locked();
    t_unmapped();
    t_fifo_rules();
    t_fifo_order();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule